// File: doc/BRIEF.md
# Receive Status-Word Frame Splitter

This block takes the contents of one received bulk transfer, delivered as a byte stream, and cuts it into the Ethernet frames packed inside it. A transfer starts with a one-cycle `xfer_start` pulse that carries the byte count of the buffer. Each frame in the buffer sits behind a 4-byte little-endian status word that carries the frame length and an error-summary bit. The block forwards only the frame payload. The trailing 4-byte frame check sequence and the filler bytes that realign the next status word to a 4-byte boundary are consumed and never appear at the output.

Malformed buffers are reported on a one-cycle error pulse with a 2-bit cause code. The rest of that transfer is then swallowed without output. Every transfer, whether clean or failed, ends with a one-cycle `xfer_done` pulse once all of its bytes have been taken.

Both byte streams use valid/ready. A byte moves when valid and ready are high together on a rising clock edge. `out_valid` never depends on `out_ready`. While a payload byte is offered and `out_ready` is low, `in_ready` stays low, so no input byte is lost. `in_valid` may drop at any time.

Top module: `rx_status_deframer`

## Requirements
- R1: The status word is read little-endian: the first byte of the word is bits 7:0. Frame length L is bits 29:16. Bits 31:30 and 14:0 are ignored. Each good frame is forwarded as L-4 bytes, with `out_sop` on the first byte, `out_eop` on the last byte, and `out_len` = L-4 shown on every byte of the frame.
- R2: The last 4 bytes of each frame (the FCS) are consumed from the input and never forwarded.
- R3: After a frame, filler bytes are consumed until the offset from the start of the buffer is a multiple of 4. Filler is cut short if the buffer ends first, and it is never forwarded.
- R4: A transfer may hold any number of frames. When the remaining count reaches zero at a status-word boundary, the transfer ends with no error, `xfer_done` pulses for one cycle and `busy` falls in that same cycle. A zero-length transfer ends at once with no output.
- R5: If bit 15 of a status word is 1, `err_valid` pulses with code 2 and nothing of that frame is forwarded. Frames before it in the transfer are delivered normally.
- R6: If 1 to 3 bytes remain where a status word is expected, `err_valid` pulses with code 1.
- R7: If L is 4 or less, or L is larger than the bytes left after the status word, `err_valid` pulses with code 3.
- R8: A transfer length above 2048 gives `err_valid` with code 0 in the cycle after the start. A length of exactly 2048 is processed normally.
- R9: After any error, all remaining bytes of the transfer are consumed with no output, and then `xfer_done` pulses. `err_valid` lasts one cycle and never coincides with `xfer_done`.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low.
- R11: `xfer_start` is ignored while `busy` is high. While `busy` is low, `in_ready` and `out_valid` are low.
- R12: After reset, `busy`, `in_ready`, `out_valid`, `err_valid` and `xfer_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Begin a transfer (only taken when idle) |
| xfer_len | input | LEN_W | Byte count of the transfer, sampled with `xfer_start` |
| busy | output | 1 | A transfer is in progress |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream accepts the payload byte |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |
| out_len | output | FLEN_W | Payload length of the current frame |
| err_valid | output | 1 | One-cycle malformed-buffer pulse |
| err_code | output | 2 | Cause: 0 transfer too long, 1 short status word, 2 error bit, 3 bad length |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Directed buffers test the layout cases one at a time:
- Frame lengths of 5, 6 and 7 give each of the three filler sizes.
- A buffer that ends inside its filler shows the filler being truncated.
- Four 508-byte frames fill exactly 2048 bytes, and a 2100-byte transfer is rejected.
- A buffer of zero length is included.
- Each error cause is placed after a good frame, so delivery and discard are told apart.

Randomly generated multi-frame buffers mix frame lengths, set error bits and cut buffer tails. They run under throttled input valid and output ready, which exposes byte loss or duplication under back-pressure. One run pulses a second start mid-transfer, to show that the start is ignored while busy.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int HDR_BYTES   = 4;
  localparam int FCS_BYTES   = 4;
  localparam int ALIGN_BYTES = 4;
  localparam int ALIGN_W     = $clog2(ALIGN_BYTES);

  typedef enum logic [1:0] {
    ERR_XFER_LONG = 2'd0,
    ERR_SHORT_HDR = 2'd1,
    ERR_STATUS    = 2'd2,
    ERR_BAD_LEN   = 2'd3
  } rxd_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CHK,
    ST_PAY,
    ST_FCS,
    ST_PAD,
    ST_DRAIN
  } rxd_state_e;
endpackage

// File: rtl/rxd_hdr_capture.sv
// Collects the fields of the little-endian status word byte by byte.
module rxd_hdr_capture #(
  parameter int FLEN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        byte_idx,
  input  logic [7:0]        byte_in,
  output logic [FLEN_W-1:0] flen,
  output logic              err_flag
);
  localparam int HI_W = FLEN_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  logic            err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      err_q <= 1'b0;
    end else if (cap_en) begin
      case (byte_idx)
        2'd1:    err_q <= byte_in[7];          // word bit 15
        2'd2:    lo_q  <= byte_in;             // word bits 23:16
        2'd3:    hi_q  <= byte_in[HI_W-1:0];   // word bits 29:24
        default: ;
      endcase
    end
  end

  assign flen     = {hi_q, lo_q};
  assign err_flag = err_q;
endmodule

// File: rtl/rxd_pad_calc.sv
// Filler count needed to realign to the next boundary, clipped to what remains.
module rxd_pad_calc #(
  parameter int LEN_W   = 16,
  parameter int ALIGN_W = 2
) (
  input  logic [ALIGN_W-1:0] offs_next,
  input  logic [LEN_W-1:0]   rem_next,
  output logic [ALIGN_W-1:0] pad
);
  logic [ALIGN_W-1:0] gap;

  assign gap = ALIGN_W'(0) - offs_next;
  assign pad = (rem_next < LEN_W'(gap)) ? rem_next[ALIGN_W-1:0] : gap;
endmodule

// File: rtl/rx_status_deframer.sv
module rx_status_deframer
  import rxd_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_XFER = 2048,
  parameter int FLEN_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [FLEN_W-1:0] out_len,
  output logic              err_valid,
  output logic [1:0]        err_code,
  output logic              xfer_done
);
  localparam logic [LEN_W-1:0]  MAX_L  = LEN_W'(MAX_XFER);
  localparam logic [LEN_W-1:0]  HDR_L  = LEN_W'(HDR_BYTES);
  localparam logic [FLEN_W-1:0] FCS_F  = FLEN_W'(FCS_BYTES);
  localparam logic [FLEN_W-1:0] ONE_F  = FLEN_W'(1);

  rxd_state_e         state_q;
  logic [LEN_W-1:0]   rem_q;
  logic [ALIGN_W-1:0] offs_q;
  logic [FLEN_W-1:0]  cnt_q;
  logic [FLEN_W-1:0]  len_q;
  logic [1:0]         hidx_q;
  logic               first_q;
  logic               err_q;
  rxd_err_e           code_q;
  logic               done_q;

  logic               take;
  logic [LEN_W-1:0]   rem_dec;
  logic [ALIGN_W-1:0] offs_inc;
  logic [ALIGN_W-1:0] pad_n;
  logic [FLEN_W-1:0]  hdr_flen;
  logic               hdr_err;

  assign take     = in_valid & in_ready;
  assign rem_dec  = rem_q - LEN_W'(1);
  assign offs_inc = offs_q + ALIGN_W'(1);

  rxd_hdr_capture #(.FLEN_W(FLEN_W)) i_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (state_q == ST_HDR && take),
    .byte_idx (hidx_q),
    .byte_in  (in_data),
    .flen     (hdr_flen),
    .err_flag (hdr_err)
  );

  rxd_pad_calc #(.LEN_W(LEN_W), .ALIGN_W(ALIGN_W)) i_pad (
    .offs_next (offs_inc),
    .rem_next  (rem_dec),
    .pad       (pad_n)
  );

  always_comb begin
    case (state_q)
      ST_HDR:         in_ready = (hidx_q != 2'd0) || (rem_q >= HDR_L);
      ST_PAY:         in_ready = out_ready;
      ST_FCS, ST_PAD: in_ready = 1'b1;
      ST_DRAIN:       in_ready = (rem_q != '0);
      default:        in_ready = 1'b0;
    endcase
  end

  assign out_valid = (state_q == ST_PAY) && in_valid;
  assign out_data  = in_data;
  assign out_sop   = first_q;
  assign out_eop   = (cnt_q == ONE_F);
  assign out_len   = len_q;
  assign busy      = (state_q != ST_IDLE);
  assign err_valid = err_q;
  assign err_code  = code_q;
  assign xfer_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      offs_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      hidx_q  <= 2'd0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_XFER_LONG;
      done_q  <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      if (take) begin
        rem_q  <= rem_dec;
        offs_q <= offs_inc;
      end
      case (state_q)
        ST_IDLE: begin
          if (xfer_start) begin
            rem_q  <= xfer_len;
            offs_q <= '0;
            hidx_q <= 2'd0;
            if (xfer_len > MAX_L) begin
              err_q   <= 1'b1;
              code_q  <= ERR_XFER_LONG;
              state_q <= ST_DRAIN;
            end else begin
              state_q <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (hidx_q == 2'd0 && rem_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (hidx_q == 2'd0 && rem_q < HDR_L) begin
            err_q   <= 1'b1;
            code_q  <= ERR_SHORT_HDR;
            state_q <= ST_DRAIN;
          end else if (take) begin
            hidx_q <= hidx_q + 2'd1;
            if (hidx_q == 2'd3) state_q <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (hdr_err) begin
            err_q   <= 1'b1;
            code_q  <= ERR_STATUS;
            state_q <= ST_DRAIN;
          end else if (hdr_flen <= FCS_F || LEN_W'(hdr_flen) > rem_q) begin
            err_q   <= 1'b1;
            code_q  <= ERR_BAD_LEN;
            state_q <= ST_DRAIN;
          end else begin
            len_q   <= hdr_flen - FCS_F;
            cnt_q   <= hdr_flen - FCS_F;
            first_q <= 1'b1;
            state_q <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (take) begin
            first_q <= 1'b0;
            if (cnt_q == ONE_F) begin
              cnt_q   <= FCS_F;
              state_q <= ST_FCS;
            end else begin
              cnt_q <= cnt_q - ONE_F;
            end
          end
        end
        ST_FCS: begin
          if (take) begin
            if (cnt_q == ONE_F) begin
              if (pad_n == '0) begin
                state_q <= ST_HDR;
              end else begin
                cnt_q   <= FLEN_W'(pad_n);
                state_q <= ST_PAD;
              end
            end else begin
              cnt_q <= cnt_q - ONE_F;
            end
          end
        end
        ST_PAD: begin
          if (take) begin
            if (cnt_q == ONE_F) state_q <= ST_HDR;
            else                cnt_q   <= cnt_q - ONE_F;
          end
        end
        ST_DRAIN: begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int LEN_W    = 16,
  parameter int MAX_XFER = 2048,
  parameter int FLEN_W   = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_start,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              busy,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic [FLEN_W-1:0] out_len,
  input logic              err_valid,
  input logic [1:0]        err_code,
  input logic              xfer_done
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_XFER);

  assert_stall_holds_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_err_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  assert_err_done_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_valid, xfer_done}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid));

  assert_done_returns_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);

  assert_len_at_sop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (out_len != '0));

  assert_long_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xfer_start && xfer_len > MAX_L) |=> (err_valid && err_code == 2'd0));
endmodule

bind rx_status_deframer rxd_checker #(
  .LEN_W(LEN_W), .MAX_XFER(MAX_XFER), .FLEN_W(FLEN_W)
) i_rxd_checker (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_len(xfer_len),
  .busy(busy), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_sop(out_sop), .out_len(out_len), .err_valid(err_valid),
  .err_code(err_code), .xfer_done(xfer_done)
);

// File: tb/test_rx_status_deframer.sv
module test_rx_status_deframer;
  localparam int LEN_W = 16;
  localparam int FLEN_W = 14;
  localparam int XFER_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic busy, in_ready, out_valid, out_sop, out_eop, err_valid, xfer_done;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic [7:0] out_data;
  logic [FLEN_W-1:0] out_len;
  logic [1:0] err_code;

  always #4 clk = ~clk;

  rx_status_deframer i_rx_status_deframer (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_len(xfer_len),
    .busy(busy), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_len(out_len),
    .err_valid(err_valid), .err_code(err_code), .xfer_done(xfer_done)
  );

  int checks = 0;
  int fails = 0;

  logic [7:0] bq[$];
  int exp_bytes[$], exp_lens[$], exp_ends[$];
  int exp_err;
  int got_bytes[$], got_lens[$], got_ends[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_frame(input int fl, input bit eb);
    logic [31:0] w;
    w = ($urandom & 32'hC000_7FFF) | (32'(fl) << 16) | (32'(eb) << 15);
    for (int i = 0; i < 4; i++) bq.push_back(w[8*i +: 8]);
    for (int i = 0; i < fl; i++) bq.push_back(8'($urandom));
    while (bq.size() % 4 != 0) bq.push_back(8'($urandom));
  endtask

  // Reference parse following the requirements.
  task automatic model(input int len);
    int off, rem, fl;
    logic [31:0] w;
    exp_bytes.delete(); exp_lens.delete(); exp_ends.delete();
    exp_err = -1;
    if (len > 2048) begin exp_err = 0; return; end
    off = 0;
    forever begin
      rem = len - off;
      if (rem == 0) break;
      if (rem < 4) begin exp_err = 1; break; end
      w = {bq[off+3], bq[off+2], bq[off+1], bq[off]};
      if (w[15]) begin exp_err = 2; break; end
      fl = int'(w[29:16]);
      if (fl <= 4 || fl > rem - 4) begin exp_err = 3; break; end
      for (int i = 0; i < fl - 4; i++) exp_bytes.push_back(int'(bq[off+4+i]));
      exp_lens.push_back(fl - 4);
      exp_ends.push_back(exp_bytes.size());
      off = off + 4 + fl;
      off = off + ((4 - off % 4) % 4);
      if (off > len) off = len;
    end
  endtask

  function automatic string err_req(input int code);
    case (code)
      0: return "R8";
      1: return "R6";
      2: return "R5";
      3: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic run_xfer(input int vld_pct, input int rdy_pct,
                          input bit poke, input string tag);
    int len, idx, cyc, errs, dones, got_err, stall_bad, sops, eops, bad_at;
    len = bq.size();
    model(len);
    got_bytes.delete(); got_lens.delete(); got_ends.delete();
    idx = 0; cyc = 0; errs = 0; dones = 0; got_err = -1;
    stall_bad = 0; sops = 0; eops = 0;
    @(negedge clk);
    xfer_start = 1'b1;
    xfer_len = LEN_W'(len);
    while (dones == 0 && cyc < XFER_LIMIT) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        xfer_start = 1'b1;
        xfer_len = LEN_W'(8);
      end else begin
        xfer_start = 1'b0;
      end
      in_valid = (idx < len) && (($urandom % 100) < vld_pct);
      in_data = in_valid ? bq[idx] : 8'($urandom);
      out_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (err_valid) begin errs++; got_err = int'(err_code); end
      if (xfer_done) dones++;
      if (out_valid && !out_ready && in_ready) stall_bad++;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        got_bytes.push_back(int'(out_data));
        if (out_sop) begin got_lens.push_back(int'(out_len)); sops++; end
        if (out_eop) begin got_ends.push_back(got_bytes.size()); eops++; end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    xfer_start = 1'b0;
    chk(dones == 1, "R4", "transfer completion pulses", dones, 1);
    chk(idx == len, (exp_err >= 0) ? "R9" : "R3", "bytes consumed", idx, len);
    chk(got_err == exp_err, err_req(exp_err), "error code", got_err, exp_err);
    chk(errs == ((exp_err >= 0) ? 1 : 0), "R9", "error pulses", errs,
        (exp_err >= 0) ? 1 : 0);
    bad_at = -1;
    for (int i = 0; i < exp_bytes.size() && i < got_bytes.size(); i++)
      if (bad_at < 0 && got_bytes[i] != exp_bytes[i]) bad_at = i;
    chk(got_bytes.size() == exp_bytes.size(), tag, "payload byte count",
        got_bytes.size(), exp_bytes.size());
    chk(bad_at < 0, tag, "first mismatching payload index", bad_at, -1);
    chk(got_lens == exp_lens, "R1", "frame lengths at sop (count)",
        got_lens.size(), exp_lens.size());
    chk(got_ends == exp_ends && sops == eops, "R1", "eop positions (count)",
        got_ends.size(), exp_ends.size());
    chk(stall_bad == 0, "R10", "input taken while output stalled", stall_bad, 0);
    chk(!busy, "R11", "busy after transfer", int'(busy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy, "R12", "busy in reset", int'(busy), 0);
    chk(!in_ready && !out_valid, "R12", "handshake in reset",
        int'({in_ready, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!err_valid && !xfer_done, "R12", "pulses after reset",
        int'({err_valid, xfer_done}), 0);
    chk(!busy && !in_ready, "R12", "idle after reset", int'({busy, in_ready}), 0);

    // single aligned frame
    bq.delete(); add_frame(64, 0);
    run_xfer(100, 100, 0, "R2");
    // each filler size: lengths 5, 6, 7
    bq.delete(); add_frame(5, 0); add_frame(6, 0); add_frame(7, 0);
    run_xfer(80, 80, 0, "R3");
    // buffer ends inside the filler
    bq.delete(); add_frame(5, 0); void'(bq.pop_back()); void'(bq.pop_back());
    run_xfer(90, 90, 0, "R3");
    // two stray bytes where a status word should be
    bq.delete(); add_frame(20, 0); bq.push_back(8'h11); bq.push_back(8'h22);
    run_xfer(90, 90, 0, "R6");
    // error bit on the second frame
    bq.delete(); add_frame(12, 0); add_frame(30, 1); add_frame(9, 0);
    run_xfer(90, 90, 0, "R5");
    // length beyond the buffer
    bq.delete(); add_frame(10, 0); add_frame(100, 0);
    repeat (60) void'(bq.pop_back());
    run_xfer(90, 90, 0, "R7");
    // length of exactly the FCS
    bq.delete(); add_frame(4, 0); add_frame(8, 0);
    run_xfer(90, 90, 0, "R7");
    // exactly 2048 bytes accepted
    bq.delete(); for (int f = 0; f < 4; f++) add_frame(508, 0);
    run_xfer(95, 95, 0, "R8");
    // 2100 bytes rejected and drained
    bq.delete(); for (int i = 0; i < 2100; i++) bq.push_back(8'($urandom));
    run_xfer(95, 95, 0, "R8");
    // empty transfer
    bq.delete();
    run_xfer(100, 100, 0, "R4");
    // start pulsed while busy
    bq.delete(); add_frame(40, 0); add_frame(13, 0);
    run_xfer(70, 70, 1, "R11");
    // heavy back-pressure
    bq.delete(); add_frame(33, 0); add_frame(18, 0);
    run_xfer(90, 20, 0, "R10");

    for (int t = 0; t < 40; t++) begin
      int nf;
      bq.delete();
      nf = 1 + int'($urandom % 5);
      for (int f = 0; f < nf; f++)
        add_frame(5 + int'($urandom % 200), ($urandom % 12) == 0);
      if ($urandom % 5 == 0) begin
        int k;
        k = int'($urandom % 6);
        for (int i = 0; i < k; i++) void'(bq.pop_back());
      end
      run_xfer(50 + int'($urandom % 51), 30 + int'($urandom % 71), 0, "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule